// File: doc/BRIEF.md
# E1 Channelized Time-Slot Framer

This block sits between a serial E1 line stream and a byte-wide payload path. It advances one bit per cycle of a 2.048 MHz bit clock, and an 8 kHz frame pulse marks where each 256-bit frame begins. The frame is split into 32 slots of 8 bits, and each slot is sent most significant bit first.

On the receive side, the block gathers the line bits into bytes. Each payload byte is presented once, together with its slot number and a one-cycle valid strobe. On the transmit side, the block takes payload bytes through a ready/valid handshake and holds at most one of them. It shifts that byte out in the next payload slot. When no byte is waiting, it sends an all-ones idle byte and flags an underrun.

Slot 0 never carries payload. Slot 16 carries payload only when the signalling-mode input is low. That input is taken once per frame, at the frame's first bit. A frame pulse that arrives where the running count does not expect a frame start raises a sticky misalignment flag, and the counters realign to that pulse.

Top module: `e1_slot_framer`

## Requirements
- R1: A frame is 256 bit periods. The cycle with `fp_i` high is bit 0 of slot 0, and slot s covers frame bits 8s to 8s+7. Bit 8s is the most significant bit of the slot byte.
- R2: A received payload slot s appears on `rx_data_o` with `rx_slot_o` = s and `rx_valid_o` high for exactly one cycle. That cycle is the one after the slot's last bit period.
- R3: Slot 0 never gives a receive strobe, and the transmit line carries 8'hFF in slot 0.
- R4: With `sig_mode_i` = 1 (signalling), slot 16 is excluded in both directions, so 30 bytes per frame are received.
- R5: With `sig_mode_i` = 0 (non-signalling), slot 16 carries payload, so 31 bytes per frame are received.
- R6: `sig_mode_i` is sampled only in the bit-0 cycle of a frame. A change made later in a frame takes effect at the next frame.
- R7: `tx_bit_o` in the cycle after frame bit period p carries the bit for period p. A payload slot carries the oldest accepted byte, most significant bit first.
- R8: Slots excluded from payload are sent as the idle byte 8'hFF.
- R9: If no byte is held when a payload slot starts, that slot sends 8'hFF. In that case `underrun_o` is high for one cycle, the cycle after the slot's first bit period.
- R10: After the first frame pulse, a pulse at any count other than bit 0 sets `misalign_o`, which stays set until reset. The pulse cycle becomes bit 0 of a new frame.
- R11: After reset, `rx_valid_o`, `underrun_o` and `misalign_o` are 0, and `tx_bit_o` and `tx_ready_o` are 1. Until the first frame pulse, no receive strobe or underrun occurs and the line idles at 1, but one byte may still be accepted.
- R12: `tx_ready_o` is high exactly when the one-byte holding stage is empty. A handshake fills it, and the start of a payload slot empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low reset |
| fp_i | input | 1 | Frame pulse; high in the bit-0 cycle of slot 0 |
| sig_mode_i | input | 1 | 1 = signalling (slot 16 excluded), 0 = non-signalling |
| rx_bit_i | input | 1 | Serial receive line bit |
| rx_data_o | output | 8 | Received payload byte |
| rx_slot_o | output | 5 | Slot number of `rx_data_o` |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| tx_data_i | input | 8 | Payload byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Holding stage empty; byte accepted when valid and ready |
| tx_bit_o | output | 1 | Serial transmit line bit |
| underrun_o | output | 1 | One-cycle pulse when a payload slot starts with no byte held |
| misalign_o | output | 1 | Sticky frame-pulse misalignment flag |

## Verification
A bit counter that is off by any amount shows up within one slot. The receive strobes come on the wrong cycles or carry the wrong slot number, and the transmit bits leave their expected periods. A stale signalling-mode latch shows up at slot 16 of the affected frame, as a strobe that appears or goes missing. A wrong holding-stage state shows up either in `tx_ready_o` on the very next cycle or as a spurious or missing underrun at the next payload slot. A misalignment flag that clears or fails to set is visible on the cycle after the offending pulse and on every cycle after it.

// File: rtl/e1_pkg.sv
package e1_pkg;

   // Decide whether a slot carries payload under the given signalling mode
   function automatic logic slot_carries(input int unsigned slot,
                                         input int unsigned sig_slot,
                                         input logic sig_mode);
      return (slot != 0) && !(sig_mode && (slot == sig_slot));
   endfunction

endpackage

// File: rtl/e1_frame_timer.sv
module e1_frame_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fp_i,
   input  logic             sig_mode_i,
   output logic [CNT_W-1:0] cur_o,
   output logic             active_o,
   output logic             sig_o,
   output logic             misalign_o
);

   logic [CNT_W-1:0] nxt_q;
   logic             aligned_q;
   logic             sig_q;
   logic             misalign_q;

   // The pulse wins over the running count, so realignment takes effect in the pulse cycle
   assign cur_o      = fp_i ? '0 : nxt_q;
   assign active_o   = fp_i | aligned_q;
   assign sig_o      = sig_q;
   assign misalign_o = misalign_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_q      <= '0;
         aligned_q  <= 1'b0;
         sig_q      <= 1'b1;
         misalign_q <= 1'b0;
      end else begin
         nxt_q     <= cur_o + CNT_W'(1);
         aligned_q <= aligned_q | fp_i;
         if (active_o && (cur_o == '0))
            sig_q <= sig_mode_i;
         if (fp_i && aligned_q && (nxt_q != '0))
            misalign_q <= 1'b1;
      end
   end

   // R10
   misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_q |=> misalign_q);

   // R10
   realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fp_i |=> (fp_i || (cur_o == CNT_W'(1))));

endmodule

// File: rtl/e1_rx_deser.sv
module e1_rx_deser #(
   parameter int SLOT_BITS = 8,
   parameter int BIT_W     = 3,
   parameter int SLOT_W    = 5,
   parameter int SIG_SLOT  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active_i,
   input  logic [BIT_W-1:0]     bit_pos_i,
   input  logic [SLOT_W-1:0]    slot_i,
   input  logic                 sig_i,
   input  logic                 rx_bit_i,
   output logic [SLOT_BITS-1:0] data_o,
   output logic [SLOT_W-1:0]    slot_o,
   output logic                 valid_o
);

   logic [SLOT_BITS-1:0] sh_q;
   logic [SLOT_BITS-1:0] full_w;
   logic                 done_w;

   assign full_w = {sh_q[SLOT_BITS-2:0], rx_bit_i};
   assign done_w = active_i && (bit_pos_i == BIT_W'(SLOT_BITS-1))
                   && e1_pkg::slot_carries(int'(slot_i), SIG_SLOT, sig_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         data_o  <= '0;
         slot_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         sh_q    <= full_w;
         valid_o <= done_w;
         if (done_w) begin
            data_o <= full_w;
            slot_o <= slot_i;
         end
      end
   end

   // R2
   rx_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

endmodule

// File: rtl/e1_tx_ser.sv
module e1_tx_ser #(
   parameter int                   SLOT_BITS = 8,
   parameter int                   BIT_W     = 3,
   parameter int                   SLOT_W    = 5,
   parameter int                   SIG_SLOT  = 16,
   parameter logic [SLOT_BITS-1:0] IDLE      = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active_i,
   input  logic [BIT_W-1:0]     bit_pos_i,
   input  logic [SLOT_W-1:0]    slot_i,
   input  logic                 sig_i,
   input  logic [SLOT_BITS-1:0] data_i,
   input  logic                 valid_i,
   output logic                 ready_o,
   output logic                 bit_o,
   output logic                 underrun_o
);

   logic [SLOT_BITS-1:0] hold_q;
   logic                 full_q;
   logic [SLOT_BITS-1:0] sh_q;
   logic                 start_w;
   logic                 pay_w;
   logic                 load_w;
   logic [SLOT_BITS-1:0] sel_w;

   assign ready_o = !full_q;
   assign start_w = active_i && (bit_pos_i == '0);
   assign pay_w   = e1_pkg::slot_carries(int'(slot_i), SIG_SLOT, sig_i);
   assign load_w  = start_w && pay_w && full_q;
   assign sel_w   = load_w ? hold_q : IDLE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q     <= '0;
         full_q     <= 1'b0;
         sh_q       <= '1;
         bit_o      <= 1'b1;
         underrun_o <= 1'b0;
      end else begin
         if (valid_i && !full_q) begin
            hold_q <= data_i;
            full_q <= 1'b1;
         end else if (load_w) begin
            full_q <= 1'b0;
         end
         underrun_o <= start_w && pay_w && !full_q;
         if (!active_i) begin
            bit_o <= 1'b1;
            sh_q  <= '1;
         end else if (start_w) begin
            bit_o <= sel_w[SLOT_BITS-1];
            sh_q  <= {sel_w[SLOT_BITS-2:0], 1'b1};
         end else begin
            bit_o <= sh_q[SLOT_BITS-1];
            sh_q  <= {sh_q[SLOT_BITS-2:0], 1'b1};
         end
      end
   end

   // R9
   underrun_slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> ($past(bit_pos_i) == '0));

   // R12
   hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ready_o) |=> !ready_o);

endmodule

// File: rtl/e1_slot_framer.sv
module e1_slot_framer #(
   parameter int                   SLOT_BITS = 8,
   parameter int                   SLOTS     = 32,
   parameter int                   SIG_SLOT  = 16,
   parameter logic [SLOT_BITS-1:0] IDLE      = '1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fp_i,
   input  logic                      sig_mode_i,
   input  logic                      rx_bit_i,
   output logic [SLOT_BITS-1:0]      rx_data_o,
   output logic [$clog2(SLOTS)-1:0]  rx_slot_o,
   output logic                      rx_valid_o,
   input  logic [SLOT_BITS-1:0]      tx_data_i,
   input  logic                      tx_valid_i,
   output logic                      tx_ready_o,
   output logic                      tx_bit_o,
   output logic                      underrun_o,
   output logic                      misalign_o
);

   localparam int BIT_W  = $clog2(SLOT_BITS);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int CNT_W  = BIT_W + SLOT_W;

   generate
      if ((SLOT_BITS < 2) || ((SLOT_BITS & (SLOT_BITS - 1)) != 0))
         $error("SLOT_BITS must be a power of two of at least 2");
      if ((SLOTS < 2) || ((SLOTS & (SLOTS - 1)) != 0))
         $error("SLOTS must be a power of two of at least 2");
      if ((SIG_SLOT < 1) || (SIG_SLOT >= SLOTS))
         $error("SIG_SLOT must lie within 1 .. SLOTS-1");
   endgenerate

   logic [CNT_W-1:0] cur_w;
   logic             active_w;
   logic             sig_w;

   e1_frame_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fp_i       (fp_i),
      .sig_mode_i (sig_mode_i),
      .cur_o      (cur_w),
      .active_o   (active_w),
      .sig_o      (sig_w),
      .misalign_o (misalign_o)
   );

   e1_rx_deser #(
      .SLOT_BITS (SLOT_BITS),
      .BIT_W     (BIT_W),
      .SLOT_W    (SLOT_W),
      .SIG_SLOT  (SIG_SLOT)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active_w),
      .bit_pos_i (cur_w[BIT_W-1:0]),
      .slot_i    (cur_w[CNT_W-1:BIT_W]),
      .sig_i     (sig_w),
      .rx_bit_i  (rx_bit_i),
      .data_o    (rx_data_o),
      .slot_o    (rx_slot_o),
      .valid_o   (rx_valid_o)
   );

   e1_tx_ser #(
      .SLOT_BITS (SLOT_BITS),
      .BIT_W     (BIT_W),
      .SLOT_W    (SLOT_W),
      .SIG_SLOT  (SIG_SLOT),
      .IDLE      (IDLE)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (active_w),
      .bit_pos_i  (cur_w[BIT_W-1:0]),
      .slot_i     (cur_w[CNT_W-1:BIT_W]),
      .sig_i      (sig_w),
      .data_i     (tx_data_i),
      .valid_i    (tx_valid_i),
      .ready_o    (tx_ready_o),
      .bit_o      (tx_bit_o),
      .underrun_o (underrun_o)
   );

   // R3
   rx_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> (rx_slot_o != '0));

   // R4
   rx_sig_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && (rx_slot_o == SLOT_W'(SIG_SLOT))) |-> !sig_w);

endmodule

// File: tb/e1_slot_framer_tb.sv
module e1_slot_framer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fp = 1'b0;
   logic       sig_mode = 1'b1;
   logic       rx_bit = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic [7:0] rx_data;
   logic [4:0] rx_slot;
   logic       rx_valid;
   logic       tx_ready;
   logic       tx_bit;
   logic       underrun;
   logic       misalign;

   always #2 clk = ~clk;

   e1_slot_framer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fp_i       (fp),
      .sig_mode_i (sig_mode),
      .rx_bit_i   (rx_bit),
      .rx_data_o  (rx_data),
      .rx_slot_o  (rx_slot),
      .rx_valid_o (rx_valid),
      .tx_data_i  (tx_data),
      .tx_valid_i (tx_valid),
      .tx_ready_o (tx_ready),
      .tx_bit_o   (tx_bit),
      .underrun_o (underrun),
      .misalign_o (misalign)
   );

   int         checks = 0;
   int         errors = 0;
   bit         done = 0;
   int         nxt_b = 0;
   bit         aligned_b = 0;
   bit         mis_b = 0;
   bit         sig_b = 1;
   int         fr_b = 0;
   logic [7:0] fifo [4];
   int         wr_i = 0;
   int         rd_i = 0;
   int         cnt_b = 0;
   logic [7:0] exp_byte = 8'hFF;
   int         rx_count = 0;
   int         ur_count = 0;
   logic [7:0] tx_next = 8'h21;
   bit         feed = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rx_pat(input int fr, input int slot);
      return 8'((fr * 29 + slot * 7 + 60) ^ (slot << 3));
   endfunction

   function automatic bit carries(input int slot, input bit sig);
      return (slot != 0) && !(sig && slot == 16);
   endfunction

   task automatic step(input bit fp_v);
      int         cur;
      bit         hs;
      bit         ur_exp;
      bit         ev;
      logic [7:0] pat;
      if (fp_v) begin
         if (aligned_b && nxt_b != 0) mis_b = 1;
         cur = 0;
      end else begin
         cur = aligned_b ? nxt_b : -1;
      end
      if (cur == 0 && aligned_b) fr_b++;
      if (fp_v) aligned_b = 1;
      if (cur == 0) sig_b = sig_mode;
      pat = (cur >= 0) ? rx_pat(fr_b, cur / 8) : 8'h00;
      fp = fp_v;
      rx_bit = (cur >= 0) ? pat[7 - cur % 8] : 1'b0;
      tx_valid = feed;
      tx_data = tx_next;
      hs = feed && tx_ready;
      @(negedge clk);
      ur_exp = 0;
      if (cur < 0) begin
         chk(rx_valid == 1'b0, "R11", int'(rx_valid), 0);
         chk(tx_bit == 1'b1, "R11", int'(tx_bit), 1);
         chk(underrun == 1'b0, "R11", int'(underrun), 0);
      end else begin
         ev = (cur % 8 == 7) && carries(cur / 8, sig_b);
         chk(rx_valid == ev, (cur / 8 == 0) ? "R3" : "R2", int'(rx_valid), int'(ev));
         if (ev) begin
            chk(rx_data == pat, "R2", int'(rx_data), int'(pat));
            chk(int'(rx_slot) == cur / 8, "R1", int'(rx_slot), cur / 8);
            rx_count++;
         end
         if (cur % 8 == 0) begin
            if (carries(cur / 8, sig_b)) begin
               if (cnt_b > 0) begin
                  exp_byte = fifo[rd_i];
                  rd_i = (rd_i + 1) % 4;
                  cnt_b--;
               end else begin
                  exp_byte = 8'hFF;
                  ur_exp = 1;
               end
            end else begin
               exp_byte = 8'hFF;
            end
         end
         chk(tx_bit == exp_byte[7 - cur % 8],
             (cur / 8 == 0) ? "R3" : (carries(cur / 8, sig_b) ? "R7" : "R8"),
             int'(tx_bit), int'(exp_byte[7 - cur % 8]));
         chk(underrun == ur_exp, "R9", int'(underrun), int'(ur_exp));
         if (underrun) ur_count++;
         nxt_b = (cur + 1) % 256;
      end
      chk(misalign == mis_b, "R10", int'(misalign), int'(mis_b));
      if (hs) begin
         fifo[wr_i] = tx_next;
         wr_i = (wr_i + 1) % 4;
         cnt_b++;
         tx_next = tx_next + 8'd13;
      end
      chk(tx_ready == (cnt_b == 0), "R12", int'(tx_ready), int'(cnt_b == 0));
   endtask

   task automatic run_bits(input int n);
      for (int i = 0; i < n; i++) step(!aligned_b || nxt_b == 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_valid == 1'b0, "R11", int'(rx_valid), 0);
      chk(tx_bit == 1'b1, "R11", int'(tx_bit), 1);
      chk(underrun == 1'b0, "R11", int'(underrun), 0);
      chk(misalign == 1'b0, "R11", int'(misalign), 0);
      chk(tx_ready == 1'b1, "R11", int'(tx_ready), 1);
   endtask

   task automatic t_prealign();
      feed = 1;
      repeat (12) step(1'b0);
      chk(tx_ready == 1'b0, "R11", int'(tx_ready), 0);
   endtask

   task automatic t_signalling();
      sig_mode = 1'b1;
      feed = 1;
      for (int f = 0; f < 2; f++) begin
         rx_count = 0;
         run_bits(256);
         chk(rx_count == 30, "R4", rx_count, 30);
      end
   endtask

   task automatic t_nonsignalling();
      sig_mode = 1'b0;
      for (int f = 0; f < 2; f++) begin
         rx_count = 0;
         run_bits(256);
         chk(rx_count == 31, "R5", rx_count, 31);
      end
   endtask

   task automatic t_mode_switch();
      sig_mode = 1'b1;
      rx_count = 0;
      run_bits(50);
      sig_mode = 1'b0;
      run_bits(206);
      chk(rx_count == 30, "R6", rx_count, 30);
      rx_count = 0;
      run_bits(256);
      chk(rx_count == 31, "R6", rx_count, 31);
   endtask

   task automatic t_underrun();
      sig_mode = 1'b1;
      feed = 0;
      run_bits(256);
      ur_count = 0;
      run_bits(256);
      chk(ur_count == 30, "R9", ur_count, 30);
      feed = 1;
      ur_count = 0;
      run_bits(256);
      chk(ur_count <= 1, "R9", ur_count, 1);
   endtask

   task automatic t_misalign();
      sig_mode = 1'b1;
      chk(misalign == 1'b0, "R10", int'(misalign), 0);
      run_bits(77);
      step(1'b1);
      chk(misalign == 1'b1, "R10", int'(misalign), 1);
      rx_count = 0;
      run_bits(255);
      chk(rx_count == 30, "R10", rx_count, 30);
      run_bits(256);
      chk(misalign == 1'b1, "R10", int'(misalign), 1);
   endtask

   initial begin
      t_reset();
      t_prealign();
      t_signalling();
      t_nonsignalling();
      t_mode_switch();
      t_underrun();
      t_misalign();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule